// File: doc/BRIEF.md
# Context Propagation Scheduler

This unit stores up to seven prefix contexts and tells the pipeline which of them apply to each retiring instruction. Each context is 32 bits wide and sits in slot 1 to 7. Slot number 0 means "no prefix". Every slot owns a 40-bit bit stream. Each bit in the stream covers one upcoming instruction, and the least significant bit covers the next instruction to retire.

A setup operation does two things. It overwrites the context of the chosen slot. It then appends a short run of schedule bits behind the bits that slot already has queued. The run comes from a 21-bit immediate. The lowest set bit of the immediate is a marker. The bits above the marker are the schedule, and they are applied lowest bit first.

On every retire strobe the unit does three things. It ORs together the contexts of all slots whose head bit is set. It checks that those contexts all belong to one type class. It then advances every stream by one position.

Top module: `cprop_unit`

## Requirements
- R1: After reset, `ctx_o`, `ctx_valid_o`, `illegal_o` and `overflow_o` are all 0, and every stream is empty.
- R2: Schedule decoding works as follows. If t is the index of the lowest set bit of `ins_sched_i`, then the number of queued bits is 20−t. Immediate bit t+1+k covers the k-th instruction after the already queued bits. An immediate of zero queues nothing, but it still replaces the slot's context.
- R3: A setup on slot `ins_idx_i` (1..7) places its bits starting at that slot's current fill level. The fill level then grows by the number of bits placed. Other slots are untouched.
- R4: On a cycle with `retire_i` high, the next cycle shows the following. `ctx_o` is the OR of the contexts of every slot whose head bit was 1. `ctx_valid_o` is 1 if at least one head bit was 1.
- R5: Each retire shifts every stream right by one. Each fill level drops by one, and stops at zero.
- R6: A retire with no head bit set gives `ctx_valid_o` = 0 and `ctx_o` = 0.
- R7: The type class is read from context bits [31:24]: 0x00 is RM, 0x01 is vector-length setup, 0x1? is swizzle, 0x2? is remap, and 0x3? is subvector remap. Any other value is a reserved class. A retire that merges contexts of two or more classes sets `illegal_o` in the next cycle.
- R8: A setup whose bits would push the fill level past 40 is cut down to fit. `overflow_o` is then 1 for exactly the next cycle.
- R9: If a setup and a retire fall in the same cycle, the retire uses the state from before the setup, including the old context. The shift happens first, and the new bits are appended at the decremented fill level.
- R10: A setup with `ins_idx_i` = 0 changes nothing.
- R11: `ctx_o`, `ctx_valid_o` and `illegal_o` hold their values in cycles without a retire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ins_valid_i | input | 1 | Setup strobe |
| ins_idx_i | input | 3 | Target slot, 0 = none |
| ins_ctx_i | input | 32 | New context for the slot |
| ins_sched_i | input | 21 | Marker-terminated schedule immediate |
| retire_i | input | 1 | One instruction retires |
| ctx_o | output | 32 | Merged context of the last retire |
| ctx_valid_o | output | 1 | Some context applied on the last retire |
| illegal_o | output | 1 | Mixed type classes on the last retire |
| overflow_o | output | 1 | Last setup was truncated |

## Verification
Setup and retire can fall in the same clock. This collision tests both the ordering and the old-context rule. The directed part forces it on a slot whose head bit is set and whose context is being overwritten. The random part also issues both strobes together in many cycles. A bench model applies the shift first, then the append. It merges using the contexts as they were before the setup. Each cycle, the model's merged value, valid flag, illegal flag and overflow flag are compared against the outputs.

// File: rtl/cprop_pkg.sv
package cprop_pkg;

  typedef enum logic [2:0] {
    CLS_RM     = 3'd0,
    CLS_SETVL  = 3'd1,
    CLS_SWZ    = 3'd2,
    CLS_REMAP  = 3'd3,
    CLS_SVRMAP = 3'd4,
    CLS_RSVD   = 3'd5
  } ctx_cls_e;

  localparam int unsigned NUM_CLS = 6;

  function automatic ctx_cls_e cls_of(input logic [7:0] tbyte);
    ctx_cls_e c;
    unique case (tbyte[7:4])
      4'h0:    c = (tbyte[3:0] == 4'h0) ? CLS_RM :
                   (tbyte[3:0] == 4'h1) ? CLS_SETVL : CLS_RSVD;
      4'h1:    c = CLS_SWZ;
      4'h2:    c = CLS_REMAP;
      4'h3:    c = CLS_SVRMAP;
      default: c = CLS_RSVD;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/cprop_sched_dec.sv
module cprop_sched_dec #(
  parameter int unsigned SCHED_W = 21,
  localparam int unsigned BITS_W = SCHED_W - 1,
  localparam int unsigned CNT_W  = $clog2(SCHED_W)
) (
  input  logic [SCHED_W-1:0] imm_i,
  output logic [BITS_W-1:0]  bits_o,
  output logic [CNT_W-1:0]   cnt_o
);

  logic               found;
  logic [CNT_W-1:0]   tz;
  logic [SCHED_W-1:0] shifted;

  always_comb begin
    found = 1'b0;
    tz    = '0;
    for (int k = 0; k < SCHED_W; k++) begin
      if (!found && imm_i[k]) begin
        found = 1'b1;
        tz    = CNT_W'(k);
      end
    end
    shifted = imm_i >> tz;
    bits_o  = found ? shifted[SCHED_W-1:1] : '0;
    cnt_o   = found ? (CNT_W'(BITS_W) - tz) : '0;
  end

  always_comb begin
    assert_cnt_range_R2: assert (cnt_o <= CNT_W'(BITS_W));
  end

endmodule

// File: rtl/cprop_lane.sv
module cprop_lane #(
  parameter int unsigned DEPTH  = 40,
  parameter int unsigned CTX_W  = 32,
  parameter int unsigned BITS_W = 20,
  parameter int unsigned CNT_W  = 5,
  localparam int unsigned OFF_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              retire_i,
  input  logic              ins_en_i,
  input  logic [CTX_W-1:0]  ins_ctx_i,
  input  logic [BITS_W-1:0] ins_bits_i,
  input  logic [CNT_W-1:0]  ins_cnt_i,
  output logic              head_o,
  output logic [CTX_W-1:0]  ctx_o,
  output logic              ovf_o
);

  logic [DEPTH-1:0]        fifo_q, fifo_s, fifo_d;
  logic [OFF_W-1:0]        off_q, off_s, off_d, room, take, cnt_w;
  logic [CTX_W-1:0]        ctx_q;
  logic [BITS_W-1:0]       masked;
  logic [DEPTH+BITS_W-1:0] ext;

  // shift first, then append at the post-shift fill level
  always_comb begin
    off_s  = (retire_i && off_q != '0) ? off_q - 1'b1 : off_q;
    fifo_s = retire_i ? (fifo_q >> 1) : fifo_q;
    room   = OFF_W'(DEPTH) - off_s;
    cnt_w  = OFF_W'(ins_cnt_i);
    take   = (cnt_w > room) ? room : cnt_w;
    for (int k = 0; k < BITS_W; k++) begin
      masked[k] = ins_bits_i[k] && (OFF_W'(k) < take);
    end
    ext    = {{DEPTH{1'b0}}, masked} << off_s;
    fifo_d = ins_en_i ? (fifo_s | ext[DEPTH-1:0]) : fifo_s;
    off_d  = ins_en_i ? (off_s + take) : off_s;
    ovf_o  = ins_en_i && (cnt_w > room);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fifo_q <= '0;
      off_q  <= '0;
      ctx_q  <= '0;
    end else begin
      fifo_q <= fifo_d;
      off_q  <= off_d;
      if (ins_en_i) ctx_q <= ins_ctx_i;
    end
  end

  assign head_o = fifo_q[0];
  assign ctx_o  = ctx_q;

  assert_fill_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_q <= OFF_W'(DEPTH));

  assert_tail_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_q >> off_q) == '0);

  assert_drain_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retire_i && !ins_en_i && off_q != '0) |=> (off_q == $past(off_q) - 1'b1));

  assert_idle_lane_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!retire_i && !ins_en_i) |=> ($stable(fifo_q) && $stable(off_q)));

endmodule

// File: rtl/cprop_merge.sv
module cprop_merge
  import cprop_pkg::*;
#(
  parameter int unsigned N     = 7,
  parameter int unsigned CTX_W = 32
) (
  input  logic [N-1:0]            head_i,
  input  logic [N-1:0][CTX_W-1:0] ctx_i,
  output logic [CTX_W-1:0]        merged_o,
  output logic                    any_o,
  output logic                    conflict_o
);

  logic [NUM_CLS-1:0] seen;

  always_comb begin
    merged_o = '0;
    seen     = '0;
    for (int i = 0; i < N; i++) begin
      if (head_i[i]) begin
        merged_o = merged_o | ctx_i[i];
        seen[cls_of(ctx_i[i][CTX_W-1 -: 8])] = 1'b1;
      end
    end
    any_o      = |head_i;
    conflict_o = ($countones(seen) > 1);
  end

endmodule

// File: rtl/cprop_unit.sv
module cprop_unit #(
  parameter int unsigned NUM_CTX = 7,
  parameter int unsigned CTX_W   = 32,
  parameter int unsigned DEPTH   = 40,
  parameter int unsigned SCHED_W = 21,
  localparam int unsigned IDX_W  = $clog2(NUM_CTX + 1),
  localparam int unsigned BITS_W = SCHED_W - 1,
  localparam int unsigned CNT_W  = $clog2(SCHED_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ins_valid_i,
  input  logic [IDX_W-1:0]   ins_idx_i,
  input  logic [CTX_W-1:0]   ins_ctx_i,
  input  logic [SCHED_W-1:0] ins_sched_i,
  input  logic               retire_i,
  output logic [CTX_W-1:0]   ctx_o,
  output logic               ctx_valid_o,
  output logic               illegal_o,
  output logic               overflow_o
);

  logic [BITS_W-1:0]            dec_bits;
  logic [CNT_W-1:0]             dec_cnt;
  logic [NUM_CTX-1:0]           head, ovf;
  logic [NUM_CTX-1:0][CTX_W-1:0] ctx_bus;
  logic [CTX_W-1:0]             merged;
  logic                         any_hit, conflict;

  cprop_sched_dec #(.SCHED_W(SCHED_W)) u_dec (
    .imm_i (ins_sched_i),
    .bits_o(dec_bits),
    .cnt_o (dec_cnt)
  );

  for (genvar i = 0; i < NUM_CTX; i++) begin : g_lane
    cprop_lane #(
      .DEPTH (DEPTH),
      .CTX_W (CTX_W),
      .BITS_W(BITS_W),
      .CNT_W (CNT_W)
    ) u_lane (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .retire_i  (retire_i),
      .ins_en_i  (ins_valid_i && (ins_idx_i == IDX_W'(i + 1))),
      .ins_ctx_i (ins_ctx_i),
      .ins_bits_i(dec_bits),
      .ins_cnt_i (dec_cnt),
      .head_o    (head[i]),
      .ctx_o     (ctx_bus[i]),
      .ovf_o     (ovf[i])
    );
  end

  cprop_merge #(.N(NUM_CTX), .CTX_W(CTX_W)) u_merge (
    .head_i    (head),
    .ctx_i     (ctx_bus),
    .merged_o  (merged),
    .any_o     (any_hit),
    .conflict_o(conflict)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctx_o       <= '0;
      ctx_valid_o <= 1'b0;
      illegal_o   <= 1'b0;
      overflow_o  <= 1'b0;
    end else begin
      overflow_o <= |ovf;
      if (retire_i) begin
        ctx_o       <= merged;
        ctx_valid_o <= any_hit;
        illegal_o   <= conflict;
      end
    end
  end

  assert_illegal_needs_hit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> ctx_valid_o);

  assert_zero_when_none_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctx_valid_o |-> (ctx_o == '0));

  assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !retire_i |=> ($stable(ctx_o) && $stable(ctx_valid_o) && $stable(illegal_o)));

  assert_ovf_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> $past(ins_valid_i && ins_idx_i != '0));

  assert_one_ovf_lane_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ovf));

endmodule

// File: tb/cprop_unit_bench.sv
`timescale 1ns/1ps
module cprop_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ins_valid = 1'b0;
  logic [2:0]  ins_idx = '0;
  logic [31:0] ins_ctx = '0;
  logic [20:0] ins_sched = '0;
  logic        retire = 1'b0;
  logic [31:0] ctx_o;
  logic        ctx_valid_o, illegal_o, overflow_o;

  always #4 clk = ~clk;

  cprop_unit u_cprop_unit (
    .clk_i(clk), .rst_ni(rst_n),
    .ins_valid_i(ins_valid), .ins_idx_i(ins_idx), .ins_ctx_i(ins_ctx),
    .ins_sched_i(ins_sched), .retire_i(retire),
    .ctx_o(ctx_o), .ctx_valid_o(ctx_valid_o),
    .illegal_o(illegal_o), .overflow_o(overflow_o)
  );

  int checks = 0;
  int errors = 0;

  logic [39:0] m_fifo [7];
  int          m_off  [7];
  logic [31:0] m_ctx  [7];
  logic [31:0] e_ctx;
  logic        e_valid, e_ill, e_ovf;

  function automatic int cls_ref(input logic [7:0] b);
    if (b == 8'h00) return 0;
    if (b == 8'h01) return 1;
    if (b[7:4] == 4'h1) return 2;
    if (b[7:4] == 4'h2) return 3;
    if (b[7:4] == 4'h3) return 4;
    return 5;
  endfunction

  // builds an immediate queueing n bits (LSB first) from pattern p
  function automatic logic [20:0] mk_imm(input logic [19:0] p, input int n);
    logic [20:0] r;
    int t;
    if (n == 0) return 21'h100000;
    t = 20 - n;
    r = 21'(1) << t;
    for (int k = 0; k < n; k++) r[t + 1 + k] = p[k];
    return r;
  endfunction

  task automatic model(input logic ie, input logic [2:0] idx, input logic [31:0] c,
                       input logic [20:0] imm, input logic rt);
    int n, tz, take, cls0;
    logic hit;
    e_ovf = 1'b0;
    if (rt) begin
      e_ctx = '0; hit = 1'b0; e_ill = 1'b0; cls0 = -1;
      for (int i = 0; i < 7; i++) begin
        if (m_fifo[i][0]) begin
          e_ctx = e_ctx | m_ctx[i];
          hit = 1'b1;
          if (cls0 < 0) cls0 = cls_ref(m_ctx[i][31:24]);
          else if (cls0 != cls_ref(m_ctx[i][31:24])) e_ill = 1'b1;
        end
      end
      e_valid = hit;
      for (int i = 0; i < 7; i++) begin
        m_fifo[i] = m_fifo[i] >> 1;
        if (m_off[i] > 0) m_off[i]--;
      end
    end
    if (ie && idx != 0) begin
      tz = 21;
      for (int k = 20; k >= 0; k--) if (imm[k]) tz = k;
      n = (tz >= 20) ? 0 : 20 - tz;
      take = (n > 40 - m_off[idx-1]) ? 40 - m_off[idx-1] : n;
      e_ovf = (n > take);
      for (int k = 0; k < take; k++)
        m_fifo[idx-1][m_off[idx-1] + k] = imm[tz + 1 + k];
      m_off[idx-1] += take;
      m_ctx[idx-1] = c;
    end
  endtask

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic ie, input logic [2:0] idx, input logic [31:0] c,
                      input logic [20:0] imm, input logic rt, input string tag);
    @(negedge clk);
    ins_valid = ie; ins_idx = idx; ins_ctx = c; ins_sched = imm; retire = rt;
    @(posedge clk);
    model(ie, idx, c, imm, rt);
    #2;
    chk(tag, "ctx_o", ctx_o, e_ctx);
    chk(tag, "ctx_valid_o", {31'b0, ctx_valid_o}, {31'b0, e_valid});
    chk(tag, "illegal_o", {31'b0, illegal_o}, {31'b0, e_ill});
    chk(tag, "overflow_o", {31'b0, overflow_o}, {31'b0, e_ovf});
  endtask

  task automatic ret(input string tag);
    step(1'b0, 3'd0, 32'h0, 21'h0, 1'b1, tag);
  endtask

  task automatic drain();
    for (int k = 0; k < 42; k++) ret("R5");
  endtask

  function automatic logic [31:0] rnd_ctx();
    logic [31:0] v;
    int t;
    v = $urandom;
    t = $urandom % 10;
    if (t < 6) v[31:24] = 8'h00;
    else if (t == 6) v[31:24] = 8'h01;
    else if (t == 7) v[31:28] = 4'h1;
    else if (t == 8) v[31:28] = 4'h2;
    else v[31:28] = 4'h3;
    return v;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7331));
    for (int i = 0; i < 7; i++) begin m_fifo[i] = '0; m_off[i] = 0; m_ctx[i] = '0; end
    e_ctx = '0; e_valid = 1'b0; e_ill = 1'b0; e_ovf = 1'b0;
    #3;
    chk("R1", "ctx_o in reset", ctx_o, 32'h0);
    chk("R1", "flags in reset", {29'b0, ctx_valid_o, illegal_o, overflow_o}, 32'h0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    ret("R6");
    // R2: pattern 1,0,1,1 then nothing
    step(1'b1, 3'd1, 32'h000000A5, mk_imm(20'hD, 4), 1'b0, "R2");
    for (int k = 0; k < 6; k++) ret("R2");
    // R3: append behind queued bits
    step(1'b1, 3'd2, 32'h00001100, mk_imm(20'h3, 2), 1'b0, "R3");
    step(1'b1, 3'd2, 32'h00001100, mk_imm(20'h5, 3), 1'b0, "R3");
    for (int k = 0; k < 6; k++) ret("R3");
    // R4: OR of two same-class contexts
    step(1'b1, 3'd3, 32'h000F0000, mk_imm(20'h1, 1), 1'b0, "R4");
    step(1'b1, 3'd4, 32'h00000F0F, mk_imm(20'h1, 1), 1'b0, "R4");
    ret("R4");
    ret("R6");
    // R7: remap vs swizzle mix
    step(1'b1, 3'd5, 32'h21000000, mk_imm(20'h1, 1), 1'b0, "R7");
    step(1'b1, 3'd6, 32'h15000000, mk_imm(20'h1, 1), 1'b0, "R7");
    ret("R7");
    // R2: zero immediate still replaces the context
    step(1'b1, 3'd7, 32'h000000C3, mk_imm(20'h1, 1), 1'b0, "R2");
    step(1'b1, 3'd7, 32'h0000003C, 21'h0, 1'b0, "R2");
    ret("R2");
    ret("R2");
    // R11: hold across idle cycles
    for (int k = 0; k < 3; k++) step(1'b0, 3'd0, 32'h0, 21'h0, 1'b0, "R11");
    drain();
    // R8: overflow truncation
    step(1'b1, 3'd1, 32'h00000001, mk_imm(20'hFFFFF, 20), 1'b0, "R8");
    step(1'b1, 3'd1, 32'h00000001, mk_imm(20'h00000, 20), 1'b0, "R8");
    step(1'b1, 3'd1, 32'h00000001, mk_imm(20'h1F, 5), 1'b0, "R8");
    step(1'b0, 3'd0, 32'h0, 21'h0, 1'b0, "R8");
    drain();
    // R9: collision on a slot with a pending head bit
    step(1'b1, 3'd3, 32'h00000011, mk_imm(20'h3, 2), 1'b0, "R9");
    step(1'b1, 3'd3, 32'h00000022, mk_imm(20'h1, 2), 1'b1, "R9");
    for (int k = 0; k < 4; k++) ret("R9");
    // R10: slot 0 setup changes nothing
    step(1'b1, 3'd0, 32'h00FFFFFF, mk_imm(20'hFFFFF, 20), 1'b0, "R10");
    ret("R10");
    drain();
    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic ie, rt;
      logic [2:0] idx;
      int cnt;
      ie  = ($urandom % 3) == 0;
      rt  = ($urandom % 2) == 0;
      idx = 3'($urandom % 8);
      cnt = $urandom % 21;
      step(ie, idx, rnd_ctx(), mk_imm(20'($urandom), cnt), rt,
           (ie && rt) ? "R9" : "R4");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule